// File: doc/BRIEF.md
# SD Host Data-Phase Controller

This block runs the data phase of an SD/MMC host. Software sets a block-size exponent, a direction, a byte count and a timeout value through a small register bus, then starts the phase. Data words move between the processor (or a DMA engine) and the card side through a word-wide FIFO. The processor side reaches that FIFO through a single 32-bit window register, four bytes per access. The block tracks the bytes still owed on each side and drives ready flags that pace the transfer. When the transfer finishes or stalls, it records the outcome in sticky status bits.

The serial DAT-line engine is not part of this block. A card-side agent pushes received words in, or pulls words out for sending. It strobes once per card clock and reports a CRC verdict at the end of each block. The controller tells that agent which word closes a block. It also holds the selected card bus width and checks each width request against a width limit fixed at build time.

Top module: `sd_data_ctrl`

## Requirements
- R1: After reset:
  - the control register reads 0 and the status register reads 0;
  - the FIFO-depth register (offset 68) reads DEPTH, in 32-bit words;
  - the bus-width register (offset 60) reads {BUS_SUP in bits 4:3, 1-bit mode in bit 0};
  - `dma_req` is low.
- R2: Control register (offset 28) bit layout:
  - bits 3:0 hold the block-size exponent and bit 4 selects write direction (processor to card);
  - bit 5 enables DMA requests and bit 7 selects threshold pacing;
  - writing bit 6 as 1 starts a phase, and bit 6 reads back as 1 while the phase is active.
  All of these bits read back as written.
- R3: Writing bit 8 of the control register empties the FIFO, clears the byte counts of both sides and ends any active phase. The bit clears itself one cycle later, so a later read shows 0.
- R4: In read direction the card side may push a word only while `card_can_push` is high. That output drops once the programmed byte count has been received. Pushed words leave through the data window (offset 64) in arrival order. Status bit 9 (read-ready) is high while data waits.
- R5: In write direction, words written to the data window reach `card_pull_data` in order. Status bit 8 (write-ready) is high while the FIFO has room and bytes are still owed.
- R6: Each window access counts min(4, remaining) bytes. When the processor side has reached zero bytes and the FIFO is empty, status bit 7 (data end) becomes set and control bit 6 returns to 0.
- R7: The timer value (offset 32) loads when a phase starts. A card-clock strobe with no card word transfer counts it down. A card word transfer reloads it. The strobe that meets a count of 1 or less sets status bit 3 (timeout) and ends the phase.
- R8: A CRC report sets status bit 5 (good) or bit 1 (bad). Writing 1s to the clear register (offset 44) clears the matching sticky bits 1, 3, 5, 7 and 13.
- R9: With DMA enabled, `dma_req` follows the write-ready condition in write direction and the read-ready condition in read direction.
- R10: A window read with no data waiting, or a window write with no room or no bytes owed, changes nothing. The read returns 0, and sticky status bit 13 becomes set.
- R11: With threshold pacing on:
  - write-ready needs at least DEPTH/2 free entries;
  - read-ready needs at least DEPTH/2 stored words, or enough stored words to cover every remaining byte.
- R12: `card_blk_last` is high when the next card word completes a block of 2^exponent bytes, or when it is the final word of the transfer.
- R13: The bus-width register accepts a write only if bits 2:0 are one-hot (bit 0 = 1-bit, bit 1 = 4-bit, bit 2 = 8-bit) and the chosen width is within BUS_SUP (0: 1-bit, 1: up to 4-bit, 2: up to 8-bit). Any other write is ignored. `bus_sel` mirrors the stored choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata after the next edge |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dma_req | output | 1 | DMA service request |
| card_clk_stb | input | 1 | One pulse per card clock, paces the timeout |
| card_push | input | 1 | Card side delivers a received word |
| card_push_data | input | 32 | Received word |
| card_can_push | output | 1 | Card side may push this cycle |
| card_pull | input | 1 | Card side takes a word to send |
| card_pull_data | output | 32 | Word at the FIFO head |
| card_can_pull | output | 1 | A word is available to the card side |
| card_blk_last | output | 1 | Next card word closes a block |
| crc_valid | input | 1 | CRC verdict strobe for one block |
| crc_good | input | 1 | CRC verdict, 1 = match |
| bus_sel | output | 3 | One-hot card bus width selection |

## Verification
Two pairs of functions can land on the same edge.

The first pair is the timeout countdown and a card word transfer. The bench brings the counter to 1 and then drives a strobe and a card push in the same cycle. It expects no timeout: the transfer must reload the counter. After that reload, exactly two further idle strobes must raise the timeout.

The second pair is a card-side FIFO move and a processor-side FIFO move. This is exercised under threshold pacing and DMA. The bench judges the ready bits and `dma_req` against FIFO occupancy, which it computes itself.

// File: rtl/sdd_pkg.sv
`timescale 1ns/1ps
package sdd_pkg;
  localparam int unsigned ADDR_W = 7;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] A_CTRL = 7'd28;
  localparam logic [ADDR_W-1:0] A_TMR  = 7'd32;
  localparam logic [ADDR_W-1:0] A_LEN  = 7'd36;
  localparam logic [ADDR_W-1:0] A_STAT = 7'd40;
  localparam logic [ADDR_W-1:0] A_CLR  = 7'd44;
  localparam logic [ADDR_W-1:0] A_BUS  = 7'd60;
  localparam logic [ADDR_W-1:0] A_WIN  = 7'd64;
  localparam logic [ADDR_W-1:0] A_FEAT = 7'd68;

  // Status bit positions
  localparam int unsigned B_CRC_BAD = 1;
  localparam int unsigned B_TMO     = 3;
  localparam int unsigned B_CRC_OK  = 5;
  localparam int unsigned B_END     = 7;
  localparam int unsigned B_WRDY    = 8;
  localparam int unsigned B_RRDY    = 9;
  localparam int unsigned B_WIN_ERR = 13;

  typedef struct packed {
    logic       thr;
    logic       dma;
    logic       wr;
    logic [3:0] exp;
  } xfer_cfg_t;
endpackage

// File: rtl/sdd_fifo.sv
`timescale 1ns/1ps
module sdd_fifo #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wptr_q <= wptr_q + 1'b1;
      if (pop)  rptr_q <= rptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rptr_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R10: the caller's gating must never let a push land on a full FIFO
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  // R10: nor a pop on an empty one
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/sdd_timer.sv
`timescale 1ns/1ps
module sdd_timer #(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             run,
  input  logic             stb,
  input  logic             kick,
  output logic             fire
);
  logic [TMR_W-1:0] cnt_q, rel_q;

  assign fire = run && stb && !kick && (cnt_q <= TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
      rel_q <= load_val;
    end else if (kick) begin
      cnt_q <= rel_q;
    end else if (run && stb && cnt_q > TMR_W'(1)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: card activity restores the full timeout window
  a_r7_kick_reload: assert property (@(posedge clk) disable iff (rst)
    (kick && !load) |=> (cnt_q == $past(rel_q)));
endmodule

// File: rtl/sdd_card_track.sv
`timescale 1ns/1ps
module sdd_card_track #(
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             step,
  input  logic [3:0]       exp,
  output logic             has_bytes,
  output logic             blk_last
);
  logic [LEN_W-1:0] rem_q, off_q;
  logic [LEN_W-1:0] dec, mask, nxt_off;

  always_comb begin
    dec       = (rem_q >= LEN_W'(4)) ? LEN_W'(4) : rem_q;
    mask      = (LEN_W'(1) << exp) - LEN_W'(1);
    nxt_off   = off_q + LEN_W'(4);
    has_bytes = (rem_q != '0);
    blk_last  = ((nxt_off & mask) == '0) || (rem_q <= LEN_W'(4));
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rem_q <= '0;
      off_q <= '0;
    end else if (load) begin
      rem_q <= len;
      off_q <= '0;
    end else if (step) begin
      rem_q <= rem_q - dec;
      off_q <= nxt_off;
    end
  end

  // R12: a card word is only moved while the card side still owes bytes
  a_r12_step_has_bytes: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !clear) |-> (rem_q != '0));
endmodule

// File: rtl/sd_data_ctrl.sv
`timescale 1ns/1ps
module sd_data_ctrl
  import sdd_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned TMR_W   = 32,
  parameter int unsigned LEN_W   = 24,
  parameter int unsigned BUS_SUP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              dma_req,
  input  logic              card_clk_stb,
  input  logic              card_push,
  input  logic [31:0]       card_push_data,
  output logic              card_can_push,
  input  logic              card_pull,
  output logic [31:0]       card_pull_data,
  output logic              card_can_pull,
  output logic              card_blk_last,
  input  logic              crc_valid,
  input  logic              crc_good,
  output logic [2:0]        bus_sel
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned CW   = AW + 1;
  localparam int unsigned HALF = DEPTH / 2;
  localparam logic [1:0]  SUP  = 2'(BUS_SUP);

  xfer_cfg_t        cfg_q;
  logic             active_q, flush_q;
  logic [LEN_W-1:0] len_q, host_rem_q, host_dec;
  logic [TMR_W-1:0] tmr_q;
  logic [2:0]       bus_q;
  logic             st_crc_bad, st_tmo, st_crc_ok, st_end, st_win_err;

  // register decode
  logic wr_ctrl, wr_clr, wr_bus, win_wr, win_rd, do_flush, do_start;
  always_comb begin
    wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    wr_clr   = reg_wr && (reg_addr == A_CLR);
    wr_bus   = reg_wr && (reg_addr == A_BUS);
    win_wr   = reg_wr && (reg_addr == A_WIN);
    win_rd   = reg_rd && (reg_addr == A_WIN);
    do_flush = wr_ctrl && reg_wdata[8];
    do_start = wr_ctrl && reg_wdata[6] && !reg_wdata[8];
  end

  // FIFO
  logic          f_push, f_pop, f_full, f_empty;
  logic [31:0]   f_din, f_dout;
  logic [CW-1:0] f_cnt, f_free;

  // card-side tracker
  logic card_has, card_push_acc, card_pull_acc, card_step;

  // host side
  logic host_push, host_pop, win_err, end_cond, tmo_fire;
  logic wr_rdy, rd_rdy;

  always_comb begin
    f_free        = CW'(DEPTH) - f_cnt;
    host_dec      = (host_rem_q >= LEN_W'(4)) ? LEN_W'(4) : host_rem_q;
    card_can_push = active_q && !cfg_q.wr && card_has && !f_full;
    card_can_pull = active_q && cfg_q.wr && !f_empty;
    card_push_acc = card_push && card_can_push;
    card_pull_acc = card_pull && card_can_pull;
    card_step     = card_push_acc || card_pull_acc;
    host_push     = win_wr && active_q && cfg_q.wr && (host_rem_q != '0) && !f_full;
    host_pop      = win_rd && active_q && !cfg_q.wr && !f_empty;
    win_err       = (win_wr && !host_push) || (win_rd && !host_pop);
    f_push        = host_push || card_push_acc;
    f_pop         = host_pop || card_pull_acc;
    f_din         = host_push ? reg_wdata : card_push_data;
    end_cond      = active_q && (host_rem_q == '0) && f_empty;
    wr_rdy = active_q && cfg_q.wr && (host_rem_q != '0) &&
             (cfg_q.thr ? (f_free >= CW'(HALF)) : !f_full);
    rd_rdy = active_q && !cfg_q.wr && !f_empty &&
             (!cfg_q.thr || (f_cnt >= CW'(HALF)) ||
              (LEN_W'({f_cnt, 2'b00}) >= host_rem_q));
    dma_req        = cfg_q.dma && (wr_rdy || rd_rdy);
    card_pull_data = f_dout;
    bus_sel        = bus_q;
  end

  sdd_fifo #(.DEPTH(DEPTH), .DATA_W(32)) u_fifo (
    .clk(clk), .rst(rst), .flush(do_flush),
    .push(f_push), .din(f_din), .pop(f_pop),
    .dout(f_dout), .count(f_cnt), .full(f_full), .empty(f_empty)
  );

  sdd_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .load(do_start), .load_val(tmr_q),
    .run(active_q && !end_cond), .stb(card_clk_stb), .kick(card_step),
    .fire(tmo_fire)
  );

  sdd_card_track #(.LEN_W(LEN_W)) u_track (
    .clk(clk), .rst(rst), .clear(do_flush), .load(do_start), .len(len_q),
    .step(card_step), .exp(cfg_q.exp),
    .has_bytes(card_has), .blk_last(card_blk_last)
  );

  // bus-width acceptance
  logic bus_ok;
  always_comb begin
    bus_ok = (reg_wdata[2:0] == 3'b001) ||
             ((reg_wdata[2:0] == 3'b010) && (SUP >= 2'd1)) ||
             ((reg_wdata[2:0] == 3'b100) && (SUP >= 2'd2));
  end

  logic tmo_set;
  assign tmo_set = tmo_fire && !wr_ctrl;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q      <= '0;
      active_q   <= 1'b0;
      flush_q    <= 1'b0;
      len_q      <= '0;
      host_rem_q <= '0;
      tmr_q      <= '0;
      bus_q      <= 3'b001;
      st_crc_bad <= 1'b0;
      st_tmo     <= 1'b0;
      st_crc_ok  <= 1'b0;
      st_end     <= 1'b0;
      st_win_err <= 1'b0;
    end else begin
      flush_q <= do_flush;
      if (wr_ctrl)
        cfg_q <= '{thr: reg_wdata[7], dma: reg_wdata[5], wr: reg_wdata[4], exp: reg_wdata[3:0]};
      if (reg_wr && reg_addr == A_TMR) tmr_q <= reg_wdata[TMR_W-1:0];
      if (reg_wr && reg_addr == A_LEN) len_q <= reg_wdata[LEN_W-1:0];
      if (wr_bus && bus_ok) bus_q <= reg_wdata[2:0];

      if (do_flush) begin
        active_q   <= 1'b0;
        host_rem_q <= '0;
      end else if (do_start) begin
        active_q   <= 1'b1;
        host_rem_q <= len_q;
      end else if (wr_ctrl) begin
        active_q <= 1'b0;
      end else if (active_q) begin
        if (host_push || host_pop) host_rem_q <= host_rem_q - host_dec;
        if (end_cond || tmo_set) active_q <= 1'b0;
      end

      st_crc_bad <= (st_crc_bad && !(wr_clr && reg_wdata[B_CRC_BAD])) || (crc_valid && !crc_good);
      st_crc_ok  <= (st_crc_ok  && !(wr_clr && reg_wdata[B_CRC_OK]))  || (crc_valid && crc_good);
      st_tmo     <= (st_tmo     && !(wr_clr && reg_wdata[B_TMO]))     || (tmo_set && !end_cond);
      st_end     <= (st_end     && !(wr_clr && reg_wdata[B_END]))     || (end_cond && !wr_ctrl);
      st_win_err <= (st_win_err && !(wr_clr && reg_wdata[B_WIN_ERR])) || win_err;
    end
  end

  // registered read port
  logic [31:0] stat;
  always_comb begin
    stat = '0;
    stat[B_CRC_BAD] = st_crc_bad;
    stat[B_TMO]     = st_tmo;
    stat[B_CRC_OK]  = st_crc_ok;
    stat[B_END]     = st_end;
    stat[B_WRDY]    = wr_rdy;
    stat[B_RRDY]    = rd_rdy;
    stat[B_WIN_ERR] = st_win_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_CTRL:  reg_rdata <= {23'd0, flush_q, cfg_q.thr, active_q, cfg_q.dma, cfg_q.wr, cfg_q.exp};
        A_TMR:   reg_rdata <= 32'(tmr_q);
        A_LEN:   reg_rdata <= 32'(len_q);
        A_STAT:  reg_rdata <= stat;
        A_BUS:   reg_rdata <= {27'd0, SUP, bus_q};
        A_WIN:   reg_rdata <= host_pop ? f_dout : 32'd0;
        A_FEAT:  reg_rdata <= 32'(DEPTH);
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R3: the cycle after a FIFO reset the FIFO is empty and the card side is idle
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> (f_empty && !card_can_push && !card_can_pull));
  // R6: data end is only ever reached from an active phase
  a_r6_end_from_active: assert property (@(posedge clk) disable iff (rst)
    $rose(st_end) |-> $past(active_q));
  // R7: a raised timeout leaves the phase stopped
  a_r7_tmo_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(st_tmo) |-> !active_q);
  // R9: a DMA request never asks for a transfer the FIFO cannot serve
  a_r9_dma_room: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (cfg_q.wr ? !f_full : !f_empty));
  // R13: exactly one width is selected at all times
  a_r13_bus_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(bus_q) == 1);
endmodule

// File: tb/sd_data_ctrl_tb.sv
`timescale 1ns/1ps
module sd_data_ctrl_tb;
  localparam logic [6:0] CTRL = 7'd28, TMR = 7'd32, LEN = 7'd36, STAT = 7'd40,
                         CLR = 7'd44, BUS = 7'd60, WIN = 7'd64, FEAT = 7'd68;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_req;
  logic        card_clk_stb = 0, card_push = 0, card_pull = 0;
  logic [31:0] card_push_data = '0;
  logic        card_can_push, card_can_pull, card_blk_last;
  logic [31:0] card_pull_data;
  logic        crc_valid = 0, crc_good = 0;
  logic [2:0]  bus_sel;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sd_data_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .card_clk_stb(card_clk_stb), .card_push(card_push), .card_push_data(card_push_data),
    .card_can_push(card_can_push), .card_pull(card_pull), .card_pull_data(card_pull_data),
    .card_can_pull(card_can_pull), .card_blk_last(card_blk_last),
    .crc_valid(crc_valid), .crc_good(crc_good), .bus_sel(bus_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic push(input logic [31:0] d, output logic last);
    @(negedge clk); card_push = 1; card_push_data = d; last = card_blk_last;
    @(negedge clk); card_push = 0;
  endtask

  task automatic pull(output logic [31:0] d);
    @(negedge clk); card_pull = 1; d = card_pull_data;
    @(negedge clk); card_pull = 0;
  endtask

  task automatic stb(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); card_clk_stb = 1;
      @(negedge clk); card_clk_stb = 0;
    end
  endtask

  task automatic start(input logic [31:0] len, input logic [31:0] t, input logic [31:0] c);
    wr(CTRL, 32'h100);
    wr(CLR, 32'hFFFF_FFFF);
    wr(LEN, len);
    wr(TMR, t);
    wr(CTRL, c);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CTRL, v); chk("R1 ctrl at reset", v, 0);
    rd(STAT, v); chk("R1 status at reset", v, 0);
    rd(FEAT, v); chk("R1 fifo depth", v, 8);
    rd(BUS, v);  chk("R1 R13 bus reg at reset", v, 32'h09);
    chk("R1 dma_req at reset", dma_req, 0);
  endtask

  task automatic t_fifo_reset;
    logic [31:0] v;
    start(16, 100, 32'h59);
    rd(CTRL, v); chk("R2 ctrl readback", v, 32'h59);
    wr(WIN, 32'h11); wr(WIN, 32'h22);
    wr(CTRL, 32'h100);
    rd(CTRL, v); chk("R3 reset bit self-clears", v, 0);
    chk("R3 fifo emptied", card_can_pull, 0);
    wr(LEN, 4); wr(CTRL, 32'h59);
    chk("R3 fifo still empty on restart", card_can_pull, 0);
    rd(STAT, v); chk("R5 write-ready", v & 32'h100, 32'h100);
  endtask

  task automatic t_read_path;
    logic [31:0] v; logic l;
    start(12, 1000, 32'h49);
    rd(STAT, v); chk("R4 no read-ready when empty", v, 0);
    chk("R4 card may push", card_can_push, 1);
    push(32'hA0A0_0001, l); push(32'hB0B0_0002, l); push(32'hC0C0_0003, l);
    chk("R4 push closed after length", card_can_push, 0);
    rd(STAT, v); chk("R4 read-ready", v, 32'h200);
    rd(WIN, v); chk("R4 word 0", v, 32'hA0A0_0001);
    rd(WIN, v); chk("R4 word 1", v, 32'hB0B0_0002);
    rd(WIN, v); chk("R4 word 2", v, 32'hC0C0_0003);
    rd(STAT, v); chk("R6 data end after read", v, 32'h80);
    rd(CTRL, v); chk("R6 active cleared", v, 32'h09);
    wr(CLR, 32'h80);
    rd(STAT, v); chk("R8 clear data end", v, 0);
  endtask

  task automatic t_write_path;
    logic [31:0] v;
    start(6, 1000, 32'h59);
    rd(STAT, v); chk("R5 write-ready at start", v, 32'h100);
    wr(WIN, 32'h1234_5678); wr(WIN, 32'h9ABC_DEF0);
    rd(STAT, v); chk("R6 partial word counted, no more owed", v, 0);
    pull(v); chk("R5 pulled word 0", v, 32'h1234_5678);
    pull(v); chk("R5 pulled word 1", v, 32'h9ABC_DEF0);
    rd(STAT, v); chk("R6 data end after drain", v, 32'h80);
    rd(CTRL, v); chk("R6 active cleared in write", v, 32'h19);
  endtask

  task automatic t_timeout;
    logic [31:0] v; logic l;
    start(16, 3, 32'h49);
    stb(2);
    push(32'h5, l);
    stb(2);
    rd(STAT, v); chk("R7 transfer reloaded timer", v & 32'h8, 0);
    rd(CTRL, v); chk("R7 still active", v & 32'h40, 32'h40);
    stb(1);
    rd(STAT, v); chk("R7 timeout raised", v & 32'h8, 32'h8);
    rd(CTRL, v); chk("R7 phase stopped", v, 32'h09);
    chk("R7 no push after timeout", card_can_push, 0);
    // coincident strobe and card transfer at count 1
    start(16, 2, 32'h49);
    stb(1);
    @(negedge clk); card_clk_stb = 1; card_push = 1; card_push_data = 32'h77;
    @(negedge clk); card_clk_stb = 0; card_push = 0;
    rd(STAT, v); chk("R7 coincident transfer wins", v & 32'h8, 0);
    chk("R7 still accepting", card_can_push, 1);
    stb(2);
    rd(STAT, v); chk("R7 timeout after reload", v & 32'h8, 32'h8);
  endtask

  task automatic t_crc;
    logic [31:0] v;
    wr(CTRL, 32'h100); wr(CLR, 32'hFFFF_FFFF);
    @(negedge clk); crc_valid = 1; crc_good = 1;
    @(negedge clk); crc_good = 0;
    @(negedge clk); crc_valid = 0;
    rd(STAT, v); chk("R8 both crc bits", v, 32'h22);
    wr(CLR, 32'h20);
    rd(STAT, v); chk("R8 clear good only", v, 32'h02);
    wr(CLR, 32'h02);
    rd(STAT, v); chk("R8 clear bad", v, 0);
  endtask

  task automatic t_dma;
    logic [31:0] v; logic l;
    start(8, 1000, 32'h79);
    chk("R9 write dma request", dma_req, 1);
    wr(WIN, 1); wr(WIN, 2);
    chk("R9 request drops when nothing owed", dma_req, 0);
    pull(v); pull(v);
    start(4, 1000, 32'h69);
    chk("R9 no read request when empty", dma_req, 0);
    push(32'hD00D, l);
    chk("R9 read request with data", dma_req, 1);
    rd(WIN, v); chk("R9 dma read data", v, 32'hD00D);
    chk("R9 read request drops", dma_req, 0);
  endtask

  task automatic t_misuse;
    logic [31:0] v;
    wr(CTRL, 32'h100); wr(CLR, 32'hFFFF_FFFF);
    rd(WIN, v); chk("R10 idle window read returns 0", v, 0);
    rd(STAT, v); chk("R10 error flag", v, 32'h2000);
    start(4, 1000, 32'h59);
    wr(WIN, 32'hAA); wr(WIN, 32'hBB);
    rd(STAT, v); chk("R10 extra write flagged", v, 32'h2000);
    pull(v); chk("R10 first word kept", v, 32'hAA);
    chk("R10 extra word dropped", card_can_pull, 0);
  endtask

  task automatic t_thresh;
    logic [31:0] v; logic l;
    start(64, 1000, 32'hD9);
    rd(STAT, v); chk("R11 write-ready with half free", v & 32'h100, 32'h100);
    for (int i = 0; i < 5; i++) wr(WIN, i);
    rd(STAT, v); chk("R11 write-ready off below half free", v & 32'h100, 0);
    pull(v); pull(v);
    rd(STAT, v); chk("R11 write-ready back", v & 32'h100, 32'h100);
    start(64, 1000, 32'hC9);
    for (int i = 0; i < 3; i++) push(i, l);
    rd(STAT, v); chk("R11 read-ready off below half", v & 32'h200, 0);
    push(3, l);
    rd(STAT, v); chk("R11 read-ready at half", v & 32'h200, 32'h200);
    start(8, 1000, 32'hC9);
    push(7, l); push(8, l);
    rd(STAT, v); chk("R11 read-ready covers remainder", v & 32'h200, 32'h200);
  endtask

  task automatic t_blk;
    logic [4:0] pat; logic l;
    start(20, 1000, 32'h43);
    for (int i = 0; i < 5; i++) begin
      push(32'h100 + i, l);
      pat[i] = l;
    end
    chk("R12 block boundary pattern", 32'(pat), 32'h1A);
  endtask

  task automatic t_bus;
    logic [31:0] v;
    wr(BUS, 2); rd(BUS, v); chk("R13 select 4-bit", v, 32'h0A);
    chk("R13 bus_sel 4-bit", 32'(bus_sel), 2);
    wr(BUS, 4); rd(BUS, v); chk("R13 8-bit beyond support ignored", v, 32'h0A);
    wr(BUS, 3); rd(BUS, v); chk("R13 non-one-hot ignored", v, 32'h0A);
    wr(BUS, 1); rd(BUS, v); chk("R13 back to 1-bit", v, 32'h09);
    chk("R13 bus_sel 1-bit", 32'(bus_sel), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_fifo_reset();
    t_read_path();
    t_write_path();
    t_timeout();
    t_crc();
    t_dma();
    t_misuse();
    t_thresh();
    t_blk();
    t_bus();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule